// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space. Every slot holds a virtual page number, a 6-bit address-space tag, a physical frame number, a write-permit bit and a cacheable bit. A lookup hits only when both the page number and the tag match the current address-space tag, so translations that belong to different processes can stay resident side by side. No flush is needed on a context switch. All slots are compared at once.

The three most significant address bits choose a segment. Addresses whose top bit is 0 are user space and are translated. Pattern 11x is kernel virtual space and is also translated. Patterns 100 and 101 are kernel windows onto physical memory. They skip the buffer entirely: the physical address is the virtual address with its top three bits cleared. Pattern 100 is cached and pattern 101 is uncached.

There is no hardware table walk. A missing translation, a store to a read-only page, and a user-mode access outside user space are all reported as fault codes, and software handles them. Software also refills the buffer through a write port. The target slot is either given explicitly or chosen by a round-robin pointer. Single slots can be invalidated, and the whole buffer can be flushed.

Top module: `asid_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` high is answered on the next clock edge. `rsp_valid` is high in that cycle only, and `rsp_valid` is low after any cycle without `lk_valid`.
- R2: In a translated segment (top bit 0, or top two bits 11), a lookup hits a valid slot whose page number equals `lk_vaddr[31:12]` and whose tag equals `cur_asid`. The response then has `rsp_fault`=0, `rsp_paddr`={frame, `lk_vaddr[11:0]`} and `rsp_cached` equal to the slot's cacheable bit.
- R3: In a translated segment, a lookup with no matching valid slot returns `rsp_fault`=1 (miss). This includes the case where the page number matches but the tag differs. A faulting response has `rsp_paddr`=0 and `rsp_cached`=0.
- R4: When `lk_user`=0, top bits 100 give `rsp_paddr`=`lk_vaddr` with bits 31:29 cleared and `rsp_cached`=1. Top bits 101 give the same address with `rsp_cached`=0. Neither pattern faults, and the buffer contents have no effect on either.
- R5: A lookup with `lk_user`=1 and `lk_vaddr[31]`=1 returns `rsp_fault`=3 (address error), whatever the buffer holds.
- R6: A lookup with `lk_write`=1 that hits a slot whose write-permit bit is 0 returns `rsp_fault`=2 (modify). A read of the same slot translates normally, and so does a write to a permitted slot.
- R7: With `wr_en`=1 and `wr_use_index`=1, slot `wr_index` is loaded and marked valid.
- R8: With `wr_en`=1 and `wr_use_index`=0, the slot named by a round-robin pointer is loaded. The pointer is 0 after reset and advances by one, modulo 64, on each such write only.
- R9: `inv_en` clears the valid bit of slot `inv_index`. When a write targets the same slot in the same cycle, the invalidate wins.
- R10: `flush_all` clears every valid bit in one cycle.
- R11: When more than one valid slot matches, the lowest-numbered slot supplies the translation.
- R12: After reset, every slot is invalid, the pointer is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_user | input | 1 | Lookup issued in user mode |
| cur_asid | input | 6 | Current address-space tag |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cached | output | 1 | Access may be cached |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 modify, 3 address error |
| wr_en | input | 1 | Refill write |
| wr_use_index | input | 1 | 1: use wr_index, 0: use round-robin pointer |
| wr_index | input | 6 | Explicit target slot |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 6 | Address-space tag to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_writable | input | 1 | Write-permit bit to store |
| wr_cacheable | input | 1 | Cacheable bit to store |
| inv_en | input | 1 | Invalidate one slot |
| inv_index | input | 6 | Slot to invalidate |
| flush_all | input | 1 | Invalidate all slots |

## Verification
The assertions assume that `inv_index` always names an existing slot. They also assume that a response depends only on the inputs sampled in the request cycle. This means the stimulus never changes lookup inputs across the sampling edge, and it drives every input at the falling edge. The bench holds refills, invalidates and flushes apart from lookups. The only exception is one deliberate cycle in which an invalidate and a write hit the same slot together. Because of this, the reference model in the bench can apply each update in order, without modelling same-edge races between a lookup and a refill.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic                       lk_write,
  input  logic                       lk_user,
  input  logic [ASID_W-1:0]          cur_asid,
  output logic                       rsp_valid,
  output logic [PFN_W+OFF_W-1:0]     rsp_paddr,
  output logic                       rsp_cached,
  output logic [1:0]                 rsp_fault,
  input  logic                       wr_en,
  input  logic                       wr_use_index,
  input  logic [$clog2(ENTRIES)-1:0] wr_index,
  input  logic [VA_W-OFF_W-1:0]      wr_vpn,
  input  logic [ASID_W-1:0]          wr_asid,
  input  logic [PFN_W-1:0]           wr_pfn,
  input  logic                       wr_writable,
  input  logic                       wr_cacheable,
  input  logic                       inv_en,
  input  logic [$clog2(ENTRIES)-1:0] inv_index,
  input  logic                       flush_all
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IW    = $clog2(ENTRIES);
  localparam int PA_W  = PFN_W + OFF_W;
  localparam logic [1:0] F_NONE = 2'd0, F_MISS = 2'd1, F_MOD = 2'd2, F_ADDR = 2'd3;

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q, wok_q, cch_q;
  logic [IW-1:0] rr_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0] hit_idx;
  logic any_hit;
  logic [IW-1:0] wslot;

  wire [VPN_W-1:0] va_vpn  = lk_vaddr[VA_W-1:OFF_W];
  wire [2:0]       seg     = lk_vaddr[VA_W-1 -: 3];
  wire             bypass  = (seg[2:1] == 2'b10);
  wire             kernseg = seg[2];

  assign wslot = wr_use_index ? wr_index : rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == va_vpn) && (asid_q[g] == cur_asid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IW'(i);
  end
  assign any_hit = |hit_vec;

  logic [1:0]      nxt_fault;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_c;

  always_comb begin
    nxt_fault = F_NONE;
    nxt_pa    = '0;
    nxt_c     = 1'b0;
    if (lk_user && kernseg) begin
      nxt_fault = F_ADDR;
    end else if (bypass) begin
      nxt_pa = PA_W'(lk_vaddr[VA_W-4:0]);
      nxt_c  = ~seg[0];
    end else if (!any_hit) begin
      nxt_fault = F_MISS;
    end else if (lk_write && !wok_q[hit_idx]) begin
      nxt_fault = F_MOD;
    end else begin
      nxt_pa = {pfn_q[hit_idx], lk_vaddr[OFF_W-1:0]};
      nxt_c  = cch_q[hit_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= F_NONE;
      rsp_paddr  <= '0;
      rsp_cached <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_fault  <= nxt_fault;
        rsp_paddr  <= nxt_pa;
        rsp_cached <= nxt_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      if (wr_en) begin
        valid_q[wslot] <= 1'b1;
        if (!wr_use_index) rr_q <= rr_q + 1'b1;
      end
      if (inv_en)    valid_q[inv_index] <= 1'b0;
      if (flush_all) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wslot]  <= wr_vpn;
      asid_q[wslot] <= wr_asid;
      pfn_q[wslot]  <= wr_pfn;
      wok_q[wslot]  <= wr_writable;
      cch_q[wslot]  <= wr_cacheable;
    end
  end

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r1_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r3_miss_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !bypass && !(lk_user && kernseg) && !any_hit) |=> (rsp_fault == F_MISS && rsp_paddr == '0));
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10) |=>
      (rsp_fault == F_NONE && rsp_paddr == PA_W'($past(lk_vaddr[VA_W-4:0]))
       && rsp_cached == !$past(lk_vaddr[VA_W-3])));
  a_r5_user_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_user && lk_vaddr[VA_W-1]) |=> rsp_fault == F_ADDR);
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !valid_q[$past(inv_index)]);
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);
endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0] cur_asid = '0;
  logic rsp_valid, rsp_cached;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic wr_en = 0, wr_use_index = 0, wr_writable = 0, wr_cacheable = 0;
  logic [5:0] wr_index = '0, wr_asid = '0, inv_index = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic inv_en = 0, flush_all = 0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [19:0] m_vpn [64];
  logic [5:0]  m_asid [64];
  logic [19:0] m_pfn [64];
  logic [63:0] m_valid = '0, m_wok = '0, m_c = '0;
  int m_rr = 0;

  always #2 clk = ~clk;

  asid_tlb u_asid_tlb (.*);

  task automatic model(input logic [31:0] va, input logic u, input logic w, input logic [5:0] a,
                       output logic [1:0] f, output logic [31:0] pa, output logic c);
    int h = -1;
    f = 2'd0; pa = '0; c = 1'b0;
    if (u && va[31]) f = 2'd3;
    else if (va[31:30] == 2'b10) begin pa = {3'b000, va[28:0]}; c = !va[29]; end
    else begin
      for (int i = 63; i >= 0; i--)
        if (m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == a) h = i;
      if (h < 0) f = 2'd1;
      else if (w && !m_wok[h]) f = 2'd2;
      else begin pa = {m_pfn[h], va[11:0]}; c = m_c[h]; end
    end
  endtask

  task automatic look(input logic [31:0] va, input logic u, input logic w, input logic [5:0] a, input string req);
    logic [1:0] ef; logic [31:0] ep; logic ec;
    model(va, u, w, a, ef, ep, ec);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_user = u; lk_write = w; cur_asid = a;
    @(posedge clk); #1;
    lk_valid = 0;
    nchk++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_paddr !== ep || rsp_cached !== ec) begin
      nfail++;
      $display("FAIL %s va=%h: got v=%b f=%0d pa=%h c=%b, expected v=1 f=%0d pa=%h c=%b",
               req, va, rsp_valid, rsp_fault, rsp_paddr, rsp_cached, ef, ep, ec);
    end
  endtask

  task automatic put(input logic use_idx, input logic [5:0] idx, input logic [19:0] vpn,
                     input logic [5:0] a, input logic [19:0] pfn, input logic wok, input logic c);
    int s = use_idx ? int'(idx) : m_rr;
    @(negedge clk);
    wr_en = 1; wr_use_index = use_idx; wr_index = idx; wr_vpn = vpn; wr_asid = a;
    wr_pfn = pfn; wr_writable = wok; wr_cacheable = c;
    @(posedge clk); #1;
    wr_en = 0;
    m_vpn[s] = vpn; m_asid[s] = a; m_pfn[s] = pfn; m_wok[s] = wok; m_c[s] = c; m_valid[s] = 1'b1;
    if (!use_idx) m_rr = (m_rr + 1) % 64;
  endtask

  task automatic inval(input logic [5:0] idx);
    @(negedge clk);
    inv_en = 1; inv_index = idx;
    @(posedge clk); #1;
    inv_en = 0;
    m_valid[idx] = 1'b0;
  endtask

  function automatic logic [19:0] vpn_of(int i);
    return (i % 2 == 0) ? 20'h01000 + 20'(i) : 20'hC0000 + 20'(i);
  endfunction
  function automatic logic [19:0] pfn_of(int i);
    return 20'hA0000 ^ 20'(i * 37);
  endfunction

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    nchk++;
    if (rsp_valid !== 1'b0) begin nfail++; $display("FAIL R12 rsp_valid=%b expected 0", rsp_valid); end
    look(32'h0000_1234, 0, 0, 6'd0, "R12");
    look(32'hC000_0ABC, 0, 0, 6'd0, "R12");

    for (int i = 0; i < 64; i++)
      put(1, 6'(i), vpn_of(i), 6'(i % 4), pfn_of(i), i[0], i[1]);

    for (int i = 0; i < 64; i++) begin
      logic [31:0] va = {vpn_of(i), 12'((i * 61) & 12'hFFF)};
      look(va, 0, 0, 6'(i % 4), "R7 R2");
      look(va, 0, 0, 6'(i % 4) ^ 6'h20, "R3");
      look(va, 0, 1, 6'(i % 4), "R6");
      look(va, 1, 0, 6'(i % 4), (i % 2 == 1) ? "R5" : "R2");
    end

    put(1, 6'd3, 20'h80001, 6'd0, 20'h55555, 1, 1);
    look(32'h8000_1ABC, 0, 0, 6'd0, "R4");
    look(32'h8000_1ABC, 1, 0, 6'd0, "R5");
    for (int k = 0; k < 8; k++) begin
      look({3'b100, 29'(k * 32'h0123_4567)}, 0, k[0], 6'(k), "R4");
      look({3'b101, 29'(k * 32'h0765_4321)}, 0, k[0], 6'(k), "R4");
      look({3'b110, 29'(k * 32'h0111_1111)}, 1, 0, 6'(k), "R5");
    end

    put(1, 6'd40, 20'h12345, 6'd2, 20'h0BEEF, 1, 0);
    put(1, 6'd20, 20'h12345, 6'd2, 20'h0CAFE, 0, 1);
    look(32'h1234_5678, 0, 0, 6'd2, "R11");
    look(32'h1234_5678, 0, 1, 6'd2, "R11");
    inval(6'd20);
    look(32'h1234_5678, 0, 0, 6'd2, "R9");
    look(32'h1234_5678, 0, 1, 6'd2, "R9");

    @(negedge clk);
    inv_en = 1; inv_index = 6'd41;
    wr_en = 1; wr_use_index = 1; wr_index = 6'd41; wr_vpn = 20'h0ABCD; wr_asid = 6'd1;
    wr_pfn = 20'h11111; wr_writable = 1; wr_cacheable = 1;
    @(posedge clk); #1;
    inv_en = 0; wr_en = 0;
    m_vpn[41] = 20'h0ABCD; m_asid[41] = 6'd1; m_valid[41] = 1'b0;
    look(32'h0ABC_D000, 0, 0, 6'd1, "R9");

    @(negedge clk);
    flush_all = 1;
    @(posedge clk); #1;
    flush_all = 0;
    m_valid = '0;
    for (int i = 0; i < 64; i += 7)
      look({vpn_of(i), 12'h010}, 0, 0, 6'(i % 4), "R10");
    look(32'h1234_5678, 0, 0, 6'd2, "R10");

    for (int k = 0; k < 64; k++)
      put(0, 6'd0, 20'h02000 + 20'(k), 6'd5, 20'h30000 + 20'(k), 1, k[2]);
    for (int k = 0; k < 64; k++)
      look({20'h02000 + 20'(k), 12'h3C4}, 0, 1, 6'd5, "R8");
    put(0, 6'd0, 20'h03000, 6'd5, 20'h44444, 0, 1);
    look(32'h0200_0000, 0, 0, 6'd5, "R8");
    look(32'h0300_0FFF, 0, 0, 6'd5, "R8");
    inval(6'd5);
    look(32'h0200_5000, 0, 0, 6'd5, "R8");
    look(32'h0200_6000, 0, 0, 6'd5, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule